// File: doc/BRIEF.md
# Single-Burst Write Master

This block drives the write side of an AXI4 memory-mapped port. Each accepted start request turns into exactly one incrementing burst: the address channel and the data channel are launched in the same cycle, each without waiting on its own ready input, and each is retired by its own handshake. The response phase opens only after both have completed. It does not matter which finished first, or whether they finished together.

The burst payload comes from a simple pull port. The block presents the index of the next beat it wants on `src_idx` and captures `src_data` combinationally when it loads that beat. The client therefore needs only a lookup or a small buffer addressed by beat index. When the response arrives, `done` pulses for one cycle. `error` rises if the slave answered with anything other than OKAY, and stays high until the next burst is accepted.

Top module: `burst_write_master`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `awvalid`, `wvalid`, `bready`, `done` and `error` are all low.
- R2: When `start` is sampled high while the block is idle, `awvalid` and `wvalid` are both high after that edge, whatever the ready inputs do. The address payload is then `awaddr` = `base_addr`, `awlen` = `burst_len` (beats minus one), `awburst` = 2'b01 (incrementing) and `awsize` = log2 of the data bus width in bytes (2 for a 32-bit bus).
- R3: While `awvalid` is high and `awready` is low, `awvalid`, `awaddr` and `awlen` keep their values on the next cycle. After the address handshake, `awvalid` is low.
- R4: While `wvalid` is high and `wready` is low, `wvalid`, `wdata` and `wlast` keep their values on the next cycle.
- R5: A burst carries exactly `burst_len`+1 data handshakes. Beat k carries the `src_data` value presented for `src_idx` = k. `wlast` is high on the final beat only, and `wstrb` is all ones.
- R6: `bready` is high exactly from the cycle after the later of the two handshakes (the address handshake and the final data handshake) until the response handshake. This holds in every order of completion, and through long stalls on either or both channels.
- R7: After the edge on which `bvalid` and `bready` are both high, `done` is high for exactly one cycle, `bready` is low, and the block is idle.
- R8: A response code other than 2'b00 (OKAY) sets `error` on the same edge on which `done` is set. `error` stays high while the block is idle and is cleared only when the next start is accepted. An OKAY response leaves `error` low.
- R9: A `start` pulse during a burst is ignored. The running burst issues one address handshake and `burst_len`+1 data beats, and no further burst follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request one burst; taken only while idle |
| base_addr | input | ADDR_W | Byte address of the first beat |
| burst_len | input | LEN_W | Number of beats minus one |
| src_data | input | DATA_W | Payload for beat `src_idx` |
| src_idx | output | LEN_W | Index of the beat to be loaded next |
| awvalid | output | 1 | Address valid |
| awready | input | 1 | Address ready |
| awaddr | output | ADDR_W | Burst start address |
| awlen | output | LEN_W | Burst length code |
| awsize | output | 3 | Beat size code |
| awburst | output | 2 | Burst type, always incrementing |
| wvalid | output | 1 | Data valid |
| wready | input | 1 | Data ready |
| wdata | output | DATA_W | Beat payload |
| wstrb | output | DATA_W/8 | Byte enables, all ones |
| wlast | output | 1 | Final beat marker |
| bvalid | input | 1 | Response valid |
| bready | output | 1 | Response ready |
| bresp | input | 2 | Response code |
| done | output | 1 | One-cycle pulse when a burst is complete |
| error | output | 1 | Last response was not OKAY |

## Verification
The bench builds the block with a 32-bit address, a 32-bit data bus and an 8-bit length field. This makes both the single-beat burst and the 256-beat maximum burst reachable, and gives a size code of 2. The two ends of the length range check that the beat counter neither stops early nor wraps at 256. Ready patterns with long holds on either channel, or on both, force the address to finish well before the data, or the data before the address. Together with random readies, slave error codes and stray start pulses mid-burst, these cover every order of completion.

// File: rtl/wrmst_pkg.sv
// Shared types and protocol constants for the burst write master.
// Assumes AXI4 encodings for burst type and response codes.
package wrmst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_RESP = 2'd2
    } wr_state_t;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;

endpackage

// File: rtl/wr_addr_chan.sv
// Address channel of the write master.
// Raises awvalid on launch, independent of awready, and holds the payload
// until the handshake. Flags the handshake to the controller on addr_hs.
// Assumes launch only arrives while the channel is idle.
module wr_addr_chan #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic              awready,
    output logic              awvalid,
    output logic [ADDR_W-1:0] awaddr,
    output logic [LEN_W-1:0]  awlen,
    output logic              addr_hs
);

    assign addr_hs = awvalid && awready;

    // Load the address payload on launch and retire it on the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            awvalid <= 1'b0;
            awaddr  <= '0;
            awlen   <= '0;
        end else if (launch) begin
            awvalid <= 1'b1;
            awaddr  <= base_addr;
            awlen   <= burst_len;
        end else if (addr_hs) begin
            awvalid <= 1'b0;
        end
    end

    // R3: a stalled address stays valid and unchanged
    a_r3_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && !awready) |=> (awvalid && $stable(awaddr) && $stable(awlen)));

    // R3: valid drops once the address is accepted
    a_r3_aw_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_hs && !launch) |=> !awvalid);

endmodule

// File: rtl/wr_data_chan.sv
// Data channel of the write master.
// On launch, loads beat 0 from the source port and raises wvalid without
// waiting on wready. Each data handshake loads the next beat. The beat after
// index burst_len is never loaded; the final handshake clears wvalid.
// Assumes the source port returns the data for src_idx in the same cycle.
module wr_data_chan #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic [DATA_W-1:0] src_data,
    output logic [LEN_W-1:0]  src_idx,
    input  logic              wready,
    output logic              wvalid,
    output logic [DATA_W-1:0] wdata,
    output logic              wlast,
    output logic              last_hs
);

    // One spare bit so a 2**LEN_W beat burst cannot wrap the counter.
    localparam int CNT_W = LEN_W + 1;

    logic [CNT_W-1:0] load_cnt;
    logic [LEN_W-1:0] len_q;
    logic             beat_hs;

    assign beat_hs = wvalid && wready;
    assign last_hs = beat_hs && wlast;
    assign src_idx = load_cnt[LEN_W-1:0];

    // Beat loader: advances only on a real data handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wvalid   <= 1'b0;
            wdata    <= '0;
            wlast    <= 1'b0;
            load_cnt <= '0;
            len_q    <= '0;
        end else if (launch) begin
            len_q    <= burst_len;
            wvalid   <= 1'b1;
            wdata    <= src_data;
            wlast    <= (burst_len == '0);
            load_cnt <= CNT_W'(1);
        end else if (beat_hs) begin
            if (wlast) begin
                wvalid   <= 1'b0;
                wlast    <= 1'b0;
                load_cnt <= '0;
            end else begin
                wdata    <= src_data;
                wlast    <= (load_cnt == {1'b0, len_q});
                load_cnt <= load_cnt + CNT_W'(1);
            end
        end
    end

    // R4: a stalled beat stays valid and unchanged
    a_r4_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wlast)));

    // R5: the final beat ends the data phase
    a_r5_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (last_hs && !launch) |=> !wvalid);

    // R5: the counter never passes the number of beats in the burst
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid |-> (load_cnt <= {1'b0, len_q} + CNT_W'(1)));

endmodule

// File: rtl/wr_resp_ctrl.sv
// Sequencer of the write master.
// Accepts start only while idle, and records the address and final-data
// handshakes in two separate flags. It opens the response phase once both
// are in, whichever came first. It then holds bready until the response,
// pulses done, and updates the sticky error flag.
module wr_resp_ctrl
    import wrmst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       addr_hs,
    input  logic       last_hs,
    input  logic       bvalid,
    input  logic [1:0] bresp,
    output logic       launch,
    output logic       bready,
    output logic       done,
    output logic       error
);

    wr_state_t state;
    logic      aw_seen;
    logic      w_seen;
    logic      aw_fin;
    logic      w_fin;

    assign launch = (state == ST_IDLE) && start;
    assign bready = (state == ST_RESP);
    assign aw_fin = aw_seen || addr_hs;
    assign w_fin  = w_seen || last_hs;

    // Phase sequencing, acceptance flags, done pulse and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            aw_seen <= 1'b0;
            w_seen  <= 1'b0;
            done    <= 1'b0;
            error   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_DATA;
                        error   <= 1'b0;
                        aw_seen <= 1'b0;
                        w_seen  <= 1'b0;
                    end
                end
                ST_DATA: begin
                    if (aw_fin && w_fin) begin
                        state   <= ST_RESP;
                        aw_seen <= 1'b0;
                        w_seen  <= 1'b0;
                    end else begin
                        aw_seen <= aw_fin;
                        w_seen  <= w_fin;
                    end
                end
                ST_RESP: begin
                    if (bvalid) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        if (bresp != RESP_OKAY) error <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: no response phase while either channel is still outstanding
    a_r6_bready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !(aw_fin && w_fin)) |=> !bready);

    // R6: response phase follows directly once both channels are done
    a_r6_bready_open: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && aw_fin && w_fin) |=> bready);

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: an error response raises the error flag
    a_r8_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && bready && bresp != RESP_OKAY) |=> (error && done));

endmodule

// File: rtl/burst_write_master.sv
// Single-burst AXI4 write master, top level.
// Wires the address channel, the data channel and the sequencer. Burst
// type is fixed to incrementing, beat size to the full bus width, and all
// byte lanes are enabled. Assumes DATA_W is a power of two of at least 8.
module burst_write_master
    import wrmst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [LEN_W-1:0]    burst_len,
    input  logic [DATA_W-1:0]   src_data,
    output logic [LEN_W-1:0]    src_idx,
    output logic                awvalid,
    input  logic                awready,
    output logic [ADDR_W-1:0]   awaddr,
    output logic [LEN_W-1:0]    awlen,
    output logic [2:0]          awsize,
    output logic [1:0]          awburst,
    output logic                wvalid,
    input  logic                wready,
    output logic [DATA_W-1:0]   wdata,
    output logic [DATA_W/8-1:0] wstrb,
    output logic                wlast,
    input  logic                bvalid,
    output logic                bready,
    input  logic [1:0]          bresp,
    output logic                done,
    output logic                error
);

    localparam int STRB_W    = DATA_W / 8;
    localparam int SIZE_CODE = $clog2(STRB_W);

    logic launch;
    logic addr_hs;
    logic last_hs;

    assign awsize  = 3'(SIZE_CODE);
    assign awburst = BURST_INCR;
    assign wstrb   = {STRB_W{1'b1}};

    wr_resp_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .addr_hs (addr_hs),
        .last_hs (last_hs),
        .bvalid  (bvalid),
        .bresp   (bresp),
        .launch  (launch),
        .bready  (bready),
        .done    (done),
        .error   (error)
    );

    wr_addr_chan #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_aw (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .base_addr (base_addr),
        .burst_len (burst_len),
        .awready   (awready),
        .awvalid   (awvalid),
        .awaddr    (awaddr),
        .awlen     (awlen),
        .addr_hs   (addr_hs)
    );

    wr_data_chan #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_w (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .burst_len (burst_len),
        .src_data  (src_data),
        .src_idx   (src_idx),
        .wready    (wready),
        .wvalid    (wvalid),
        .wdata     (wdata),
        .wlast     (wlast),
        .last_hs   (last_hs)
    );

    // R2: both valids come up together after a launch, regardless of ready
    a_r2_launch_valids: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (awvalid && wvalid));

    // R9: no new launch while either channel is still busy
    a_r9_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid || wvalid || bready) |-> !launch);

endmodule

// File: tb/tb_burst_write_master.sv
module tb_burst_write_master;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [LEN_W-1:0]  burst_len = '0;
    logic [DATA_W-1:0] src_data;
    logic [LEN_W-1:0]  src_idx;
    logic              awvalid, awready = 1'b0;
    logic [ADDR_W-1:0] awaddr;
    logic [LEN_W-1:0]  awlen;
    logic [2:0]        awsize;
    logic [1:0]        awburst;
    logic              wvalid, wready = 1'b0;
    logic [DATA_W-1:0] wdata;
    logic [3:0]        wstrb;
    logic              wlast;
    logic              bvalid = 1'b0;
    logic              bready;
    logic [1:0]        bresp = 2'b00;
    logic              done, error;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;
    logic [7:0] cur_id = 8'h00;

    always #4 clk = ~clk;   // 125 MHz

    function automatic logic [31:0] pat(input logic [7:0] idx, input logic [7:0] id);
        return {id, idx, ~idx, id ^ idx};
    endfunction

    assign src_data = pat(src_idx, cur_id);

    burst_write_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .burst_len(burst_len), .src_data(src_data), .src_idx(src_idx),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
        .awsize(awsize), .awburst(awburst), .wvalid(wvalid), .wready(wready),
        .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .bvalid(bvalid),
        .bready(bready), .bresp(bresp), .done(done), .error(error)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit rdy(input int mode, input int cyc, input bit is_aw);
        case (mode)
            0: return 1'b1;
            1: return ($urandom % 2) == 0;
            2: return is_aw ? (cyc >= 20) : (($urandom % 4) != 0);  // data first
            3: return is_aw ? (cyc >= 5) : (cyc >= 25);             // address first
            4: return cyc >= 30;                                     // both stalled
            default: return is_aw ? 1'b1 : (($urandom % 4) == 0);
        endcase
    endfunction

    // One burst with a scripted slave; every check at a falling edge.
    task automatic run_burst(input logic [31:0] addr, input logic [7:0] len,
                             input int mode, input logic [1:0] resp, input bit poke);
        int  aw_n = 0, beats = 0, cyc = 0, bwait = -1;
        bit  both = 0, bdone = 0, aw_stall = 0, w_stall = 0;
        logic [31:0] s_addr = '0, s_wdata = '0;
        logic [7:0]  s_len = '0;
        logic        s_wlast = 1'b0;
        cur_id = cur_id + 8'd1;
        @(negedge clk);
        start = 1'b1; base_addr = addr; burst_len = len;
        awready = 1'b0; wready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(awvalid && wvalid, "R2 valids", {awvalid, wvalid}, 2'b11);
        chk(awaddr == addr, "R2 awaddr", awaddr, addr);
        chk(awlen == len, "R2 awlen", awlen, len);
        chk(awsize == 3'd2 && awburst == 2'b01, "R2 size/burst", {awsize, awburst}, {3'd2, 2'b01});
        chk(error == 1'b0, "R8 cleared on start", error, 0);
        while (!bdone && cyc < 5000) begin
            chk(bready == both, "R6 bready", bready, both);
            if (aw_stall)
                chk(awvalid && awaddr == s_addr && awlen == s_len, "R3 aw hold",
                    {awvalid, awaddr}, {1'b1, s_addr});
            if (w_stall)
                chk(wvalid && wdata == s_wdata && wlast == s_wlast, "R4 w hold",
                    {wvalid, wlast, wdata}, {1'b1, s_wlast, s_wdata});
            if (aw_n == 1 && cyc > 0)
                chk(!awvalid, "R3 aw dropped", awvalid, 0);
            awready = rdy(mode, cyc, 1'b1);
            wready  = rdy(mode, cyc, 1'b0);
            start   = (poke && (cyc == 3)) ? 1'b1 : 1'b0;
            if (poke && cyc == 3) base_addr = ~addr;
            if (awvalid && awready) begin
                aw_n++;
                chk(aw_n == 1, "R9 single address", aw_n, 1);
            end
            if (wvalid && wready) begin
                chk(wdata == pat(8'(beats), cur_id), "R5 wdata", wdata, pat(8'(beats), cur_id));
                chk(wlast == (beats == int'(len)), "R5 wlast", wlast, (beats == int'(len)));
                chk(wstrb == 4'hF, "R5 wstrb", wstrb, 4'hF);
                beats++;
            end
            aw_stall = awvalid && !awready;
            w_stall  = wvalid && !wready;
            s_addr = awaddr; s_len = awlen; s_wdata = wdata; s_wlast = wlast;
            if (bready) begin
                if (bwait < 0) bwait = int'($urandom % 3);
                if (bwait == 0) begin
                    bvalid = 1'b1; bresp = resp; bdone = 1;
                end else bwait--;
            end
            both = (aw_n == 1) && (beats == int'(len) + 1);
            cyc++;
            @(negedge clk);
        end
        if (!bdone) chk(1'b0, "R6 burst hung", cyc, 0);
        start = 1'b0; bvalid = 1'b0; awready = 1'b0; wready = 1'b0;
        chk(done == 1'b1, "R7 done pulse", done, 1);
        chk(bready == 1'b0, "R7 bready released", bready, 0);
        chk(error == (resp != 2'b00), "R8 error", error, (resp != 2'b00));
        chk(!awvalid && !wvalid, "R9 no new burst", {awvalid, wvalid}, 0);
        chk(beats == int'(len) + 1, "R5 beat count", beats, int'(len) + 1);
        chk(aw_n == 1, "R9 address count", aw_n, 1);
        @(negedge clk);
        chk(done == 1'b0, "R7 done single", done, 0);
        chk(!awvalid && !wvalid && !bready, "R9 stays idle", {awvalid, wvalid, bready}, 0);
        @(negedge clk);
        chk(error == (resp != 2'b00), "R8 sticky while idle", error, (resp != 2'b00));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(!awvalid && !wvalid && !bready && !done && !error, "R1 in reset",
            {awvalid, wvalid, bready, done, error}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!awvalid && !wvalid && !bready && !done && !error, "R1 after reset",
            {awvalid, wvalid, bready, done, error}, 0);

        run_burst(32'h0000_1000, 8'd0,   0, 2'b00, 1'b0);
        run_burst(32'h0000_2000, 8'd0,   4, 2'b10, 1'b0);
        run_burst(32'h0000_3000, 8'd3,   2, 2'b00, 1'b1);
        run_burst(32'h0000_4000, 8'd3,   3, 2'b11, 1'b0);
        run_burst(32'h0000_5000, 8'd3,   4, 2'b00, 1'b1);
        run_burst(32'h0001_0000, 8'd255, 1, 2'b00, 1'b0);
        run_burst(32'h0002_0000, 8'd255, 0, 2'b10, 1'b1);
        for (int i = 0; i < 24; i++) begin
            logic [1:0] r;
            r = (($urandom % 3) == 0) ? 2'(1 + ($urandom % 3)) : 2'b00;
            run_burst({$urandom} & 32'hFFFF_FFFC, 8'($urandom % 20),
                      int'($urandom % 6), r, 1'($urandom % 2));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule